// File: doc/BRIEF.md
# Gated Event Counter with Gate Conditioning

This block counts clock-enable ticks into a wrapping counter, and a conditioned gate signal decides which ticks are counted. The raw gate pin is first synchronized. It then passes through a polarity inverter. After that it can be reshaped in one of two ways. A toggle stage turns every rising edge into a level flip, so the gate stays open for one whole input period. A single-pulse stage, armed by a go command, opens the gate for exactly one pulse and then reports that it is done. The two stages can also be combined, and the counter then holds the length of one full input period.

The conditioned gate level can always be read, and its falling edges set a sticky event flag. The flag can raise an interrupt. Both of these keep working when gating of the counter is switched off. In that state the counter counts every tick. Software may load the counter directly. All outputs are registered.

Top module: `gated_tick_counter`

## Requirements
- R1: `gate_level` equals the synchronized, polarity-adjusted gate (when no conditioning is selected) on the third rising clock edge after `gate_raw` changes. It updates whether `gate_en` is 0 or 1.
- R2: With `gate_pol`=1 the raw gate is inverted before any conditioning, so a low `gate_raw` gives `gate_level`=1.
- R3: With `gate_en`=1 the counter adds one on each edge where `tick_en`=1 and `gate_level` was 1 before the edge. With `gate_en`=0 it adds one on every edge where `tick_en`=1.
- R4: A `load_wr` edge writes `load_val` into `count` and takes priority over an increment on the same edge. The counter wraps from all-ones to zero.
- R5: Each falling edge of `gate_level` sets `gate_flag`, whatever the value of `gate_en`. `flag_clr` clears the flag. A falling edge on the same edge as `flag_clr` wins.
- R6: `irq` is the registered AND of the next value of `gate_flag` and `irq_en`.
- R7: With `pulse_mode`=1 and `gate_en`=1, `go_wr` sets `go_busy`. `gate_level` then rises only on the next rising edge of the conditioned input, and stays 0 while that input stays high from before the go command.
- R8: In single-pulse mode, the falling edge of `gate_level` clears `go_busy` and ends the acquisition. Later pulses are not counted until `go_wr` is given again.
- R9: With `toggle_mode`=1, `gate_level` inverts one edge after each rising edge of the polarity-adjusted gate.
- R10: With toggle and single-pulse modes both on, one acquisition counts exactly one input period, measured in ticks from rising edge to rising edge.
- R11: Clearing `pulse_mode` or `gate_en` clears `go_busy` on the next edge, and `go_wr` has no effect while either of them is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count tick enable |
| gate_raw | input | 1 | Asynchronous gate input |
| gate_en | input | 1 | Gate controls counting when 1 |
| gate_pol | input | 1 | Inverts the gate when 1 |
| toggle_mode | input | 1 | Toggle conditioning enable |
| pulse_mode | input | 1 | Single-pulse conditioning enable |
| go_wr | input | 1 | Strobe that arms a single-pulse acquisition |
| flag_clr | input | 1 | Strobe that clears the gate event flag |
| irq_en | input | 1 | Interrupt enable |
| load_wr | input | 1 | Counter load strobe |
| load_val | input | CNT_W | Counter load value |
| count | output | CNT_W | Counter value |
| gate_level | output | 1 | Conditioned gate level status |
| go_busy | output | 1 | Go/done status, 1 while armed |
| gate_flag | output | 1 | Sticky gate event flag |
| irq | output | 1 | Interrupt request |

## Verification
Plain pulses of different lengths with gating on and off separate gated counting from free counting, and they show the three-edge latency of the level status. Inverted polarity and falling edges seen with gating disabled show that the status and the flag do not depend on the count path. A gate that is already high when go arrives, followed by two later pulses, separates counting that waits for a rising edge from counting that starts at once, and it shows that only one pulse is taken. A periodic gate in toggle mode, with and without single-pulse mode, tells full-period measurement apart from half-period measurement. Loading near all-ones checks the wrap and the load priority.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  typedef struct packed {
    logic en;
    logic pol;
    logic toggle;
    logic pulse;
  } gate_cfg_t;
endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/gtc_gate_cond.sv
module gtc_gate_cond
  import gtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      din,
  input  gate_cfg_t cfg,
  input  logic      go_wr,
  input  logic      flag_clr,
  input  logic      irq_en,
  output logic      level,
  output logic      go,
  output logic      flag,
  output logic      irq
);
  logic pol_in, pol_q, rise_in;
  logic tgl, tgl_n;
  logic base_c, base_q;
  logic lvl_n, fall, go_n, flag_n;

  always_comb begin
    pol_in  = din ^ cfg.pol;
    rise_in = pol_in & ~pol_q;
    tgl_n   = cfg.toggle ? (tgl ^ rise_in) : 1'b0;
    base_c  = cfg.toggle ? tgl : pol_in;

    if (!cfg.pulse)  lvl_n = base_c;
    else if (level)  lvl_n = base_c;
    else             lvl_n = go & base_c & ~base_q;

    fall = level & ~lvl_n;

    if (!cfg.pulse || !cfg.en) go_n = 1'b0;
    else if (fall)             go_n = 1'b0;
    else if (go_wr)            go_n = 1'b1;
    else                       go_n = go;

    if (fall)          flag_n = 1'b1;
    else if (flag_clr) flag_n = 1'b0;
    else               flag_n = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= 1'b0;
      tgl    <= 1'b0;
      base_q <= 1'b0;
      level  <= 1'b0;
      go     <= 1'b0;
      flag   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      pol_q  <= pol_in;
      tgl    <= tgl_n;
      base_q <= base_c;
      level  <= lvl_n;
      go     <= go_n;
      flag   <= flag_n;
      irq    <= flag_n & irq_en;
    end
  end
endmodule

// File: rtl/gtc_counter.sv
module gtc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             gate_en,
  input  logic             level,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  logic inc;

  assign inc = tick_en & (~gate_en | level);

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (load_wr) count <= load_val;
    else if (inc)     count <= count + ONE;
  end
endmodule

// File: rtl/gated_tick_counter.sv
module gated_tick_counter
  import gtc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             gate_raw,
  input  logic             gate_en,
  input  logic             gate_pol,
  input  logic             toggle_mode,
  input  logic             pulse_mode,
  input  logic             go_wr,
  input  logic             flag_clr,
  input  logic             irq_en,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             gate_level,
  output logic             go_busy,
  output logic             gate_flag,
  output logic             irq
);
  logic      gate_s;
  gate_cfg_t cfg;

  assign cfg = '{en: gate_en, pol: gate_pol, toggle: toggle_mode, pulse: pulse_mode};

  gtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(gate_raw), .q(gate_s)
  );

  gtc_gate_cond u_cond (
    .clk(clk), .rst(rst), .din(gate_s), .cfg(cfg), .go_wr(go_wr),
    .flag_clr(flag_clr), .irq_en(irq_en), .level(gate_level),
    .go(go_busy), .flag(gate_flag), .irq(irq)
  );

  gtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .gate_en(gate_en),
    .level(gate_level), .load_wr(load_wr), .load_val(load_val), .count(count)
  );
endmodule

// File: rtl/gtc_checker.sv
module gtc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             gate_en,
  input logic             pulse_mode,
  input logic             go_wr,
  input logic             irq_en,
  input logic             load_wr,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] count,
  input logic             gate_level,
  input logic             go_busy,
  input logic             gate_flag,
  input logic             irq
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R6: interrupt needs the flag and an enable from the previous cycle
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (rst || !armed)
    irq |-> (gate_flag && $past(irq_en)));

  // R5: a falling gate level always leaves the flag set
  a_r5_fall_sets_flag: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(gate_level) |-> gate_flag);

  // R4: a load writes the value
  a_r4_load_value: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(load_wr) |-> (count == $past(load_val)));

  // R3: no tick and no load keeps the count
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(load_wr) && !$past(tick_en)) |-> $stable(count));

  // R8: end of a pulse acquisition clears go
  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (rst || !armed)
    ($fell(gate_level) && $past(pulse_mode)) |-> !go_busy);

  // R11: go cannot stay set without pulse mode and gate enable
  a_r11_cancel: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(!pulse_mode || !gate_en) |-> !go_busy);

  // R7: go command arms the acquisition
  a_r7_go_sets: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(go_wr && pulse_mode && gate_en) && !$fell(gate_level)) |-> go_busy);
endmodule

bind gated_tick_counter gtc_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .gate_en(gate_en),
  .pulse_mode(pulse_mode), .go_wr(go_wr), .irq_en(irq_en),
  .load_wr(load_wr), .load_val(load_val), .count(count),
  .gate_level(gate_level), .go_busy(go_busy), .gate_flag(gate_flag), .irq(irq)
);

// File: tb/test_gated_tick_counter.sv
module test_gated_tick_counter;
  localparam int W = 16;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 0, gate_raw = 0, gate_en = 0, gate_pol = 0;
  logic toggle_mode = 0, pulse_mode = 0, go_wr = 0, flag_clr = 0, irq_en = 0, load_wr = 0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] count;
  logic gate_level, go_busy, gate_flag, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gated_tick_counter #(.CNT_W(W)) i_gated_tick_counter (
    .clk(clk), .rst(rst), .tick_en(tick_en), .gate_raw(gate_raw), .gate_en(gate_en),
    .gate_pol(gate_pol), .toggle_mode(toggle_mode), .pulse_mode(pulse_mode),
    .go_wr(go_wr), .flag_clr(flag_clr), .irq_en(irq_en), .load_wr(load_wr),
    .load_val(load_val), .count(count), .gate_level(gate_level), .go_busy(go_busy),
    .gate_flag(gate_flag), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_pipe[$] = '{1'b0, 1'b0};
  bit m_polq, m_tgl, m_baseq, m_lvl, m_go, m_flag, m_irq;
  int m_cnt;

  always @(posedge clk) begin
    bit pin, base, nl, fell, ng, nf;
    if (rst) begin
      m_pipe = '{1'b0, 1'b0};
      m_polq = 0; m_tgl = 0; m_baseq = 0; m_lvl = 0;
      m_go = 0; m_flag = 0; m_irq = 0; m_cnt = 0;
    end else begin
      pin  = m_pipe[0] ^ gate_pol;
      base = toggle_mode ? m_tgl : pin;
      if (pulse_mode && !m_lvl) nl = m_go && base && !m_baseq;
      else nl = base;
      fell = m_lvl && !nl;
      if (!gate_en || !pulse_mode || fell) ng = 0;
      else ng = go_wr ? 1'b1 : m_go;
      nf = fell ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
      if (load_wr) m_cnt = int'(load_val);
      else if (tick_en && (!gate_en || m_lvl)) m_cnt = (m_cnt + 1) % MOD;
      if (!toggle_mode) m_tgl = 0;
      else if (pin && !m_polq) m_tgl = !m_tgl;
      m_polq = pin; m_baseq = base; m_lvl = nl; m_go = ng;
      m_irq = nf && irq_en; m_flag = nf;
      void'(m_pipe.pop_front());
      m_pipe.push_back(gate_raw);
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R3 count vs model", int'(count), m_cnt);
      chk("R1 level vs model", int'(gate_level), int'(m_lvl));
      chk("R7 go vs model", int'(go_busy), int'(m_go));
      chk("R5 flag vs model", int'(gate_flag), int'(m_flag));
      chk("R6 irq vs model", int'(irq), int'(m_irq));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int v);
    load_val = W'(v); load_wr = 1; cyc(1); load_wr = 0;
  endtask

  initial begin
    int c0;
    cyc(3); rst = 0; cyc(1);
    chk("R4 reset count", int'(count), 0);
    chk("R5 reset flag", int'(gate_flag), 0);
    chk("R7 reset go", int'(go_busy), 0);

    // R3 free run when gating is off
    tick_en = 1; c0 = int'(count); cyc(10);
    chk("R3 free count", int'(count), c0 + 10);

    // R4 load priority and wrap
    load(16'hFFFE);
    chk("R4 load beats tick", int'(count), 16'hFFFE);
    cyc(2);
    chk("R4 wrap", int'(count), 0);

    // R3 gated, R1 latency
    gate_en = 1; load(0); cyc(2);
    chk("R3 closed gate holds", int'(count), 0);
    gate_raw = 1; cyc(2);
    chk("R1 level not yet", int'(gate_level), 0);
    cyc(1);
    chk("R1 level after 3 edges", int'(gate_level), 1);
    cyc(2); gate_raw = 0; cyc(10);
    chk("R3 gated count equals pulse", int'(count), 5);
    chk("R5 flag on fall", int'(gate_flag), 1);
    chk("R6 irq off when disabled", int'(irq), 0);
    irq_en = 1; cyc(1);
    chk("R6 irq follows enable", int'(irq), 1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R5 flag cleared", int'(gate_flag), 0);
    chk("R6 irq cleared", int'(irq), 0);

    // R2 polarity
    gate_pol = 1; cyc(4);
    chk("R2 inverted level", int'(gate_level), 1);
    gate_raw = 1; cyc(5);
    chk("R2 inverted low", int'(gate_level), 0);
    gate_raw = 0; gate_pol = 0; cyc(5);

    // R1/R5 with gating disabled
    gate_en = 0; flag_clr = 1; cyc(1); flag_clr = 0;
    gate_raw = 1; cyc(5);
    chk("R1 level with gate off", int'(gate_level), 1);
    gate_raw = 0; cyc(5);
    chk("R5 flag with gate off", int'(gate_flag), 1);
    flag_clr = 1; cyc(1); flag_clr = 0;

    // R7/R8 single pulse, gate already high when go arrives
    gate_en = 1; pulse_mode = 1; load(0);
    gate_raw = 1; cyc(5);
    go_wr = 1; cyc(1); go_wr = 0;
    chk("R7 go set", int'(go_busy), 1);
    cyc(5);
    chk("R7 waits for rising edge", int'(count), 0);
    gate_raw = 0; cyc(5);
    gate_raw = 1; cyc(6); gate_raw = 0; cyc(6);
    chk("R7 one pulse counted", int'(count), 6);
    chk("R8 go cleared", int'(go_busy), 0);
    gate_raw = 1; cyc(4); gate_raw = 0; cyc(6);
    chk("R8 no recount without go", int'(count), 6);

    // R11 go ignored without gate enable, cancel by mode clear
    gate_en = 0; go_wr = 1; cyc(1); go_wr = 0;
    chk("R11 go ignored gate off", int'(go_busy), 0);
    gate_en = 1; go_wr = 1; cyc(1); go_wr = 0;
    chk("R11 armed", int'(go_busy), 1);
    pulse_mode = 0; cyc(1);
    chk("R11 cancelled", int'(go_busy), 0);

    // R9 toggle only
    toggle_mode = 1; cyc(3);
    gate_raw = 1; cyc(2); gate_raw = 0; cyc(4);
    chk("R9 toggled high", int'(gate_level), 1);
    gate_raw = 1; cyc(2); gate_raw = 0; cyc(4);
    chk("R9 toggled low", int'(gate_level), 0);

    // R10 toggle plus single pulse: one full period
    pulse_mode = 1; load(0); cyc(2);
    go_wr = 1; cyc(1); go_wr = 0;
    for (int k = 0; k < 3; k++) begin
      gate_raw = 1; cyc(3); gate_raw = 0; cyc(4);
    end
    cyc(6);
    chk("R10 period count", int'(count), 7);
    chk("R10 go done", int'(go_busy), 0);

    // R3 tick_en low holds
    pulse_mode = 0; toggle_mode = 0; gate_en = 0; tick_en = 0;
    c0 = int'(count); cyc(5);
    chk("R3 no tick holds", int'(count), c0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule